// File: doc/BRIEF.md
# Converter Control Register with Self-Clearing Start Bits

This block is the write-only control word of a data converter's digital interface. A host writes a 14-bit word through a small address/data/strobe port; the word is captured only when both address lines are high. The stored fields drive the converter core. These fields are the power-management mode, the read-back register select, the input range and its data coding, a conversion start bit, the calibration mode and selection, and a calibration start bit.

The two start bits remain set while their operation runs. Each is cleared by a one-clock completion pulse from the converter core. When a start bit goes from 0 to 1, the block also issues a one-cycle start strobe. The calibration-select field has two meanings. While no calibration is running, it gives the address of the calibration coefficient register. While a calibration runs, it instead names the calibration type. Words that set any of the four upper reserved bits are refused and flagged.

Top module: `adc_ctrl_reg`

## Requirements
- R1: Word bit layout, MSB first: bits 13..10 reserved (must be 0), bits 9:8 power mode, bits 7:6 read select, bit 5 range mode, bit 4 conversion start, bit 3 calibration mode, bits 2:1 calibration select, bit 0 calibration start. An accepted write shows up on the matching outputs in the cycle after the write strobe.
- R2: A write is accepted only when `wr_en` is 1 and `wr_addr` is 2'b11. A write to any other address leaves every output unchanged.
- R3: After reset, every stored field is 0, both start strobes are 0, `wr_err` is 0 and `coef_addr_valid` is 1.
- R4: A selected write with any of bits 13..10 set is discarded, so all outputs keep their values. `wr_err` is 1 for exactly the one cycle after that write.
- R5: `twos_comp` equals the range-mode bit: 0 means unipolar with straight binary coding, and 1 means bipolar with two's-complement coding.
- R6: `conv_busy` holds the conversion start bit. A `conv_done` pulse clears it in the next cycle, unless an accepted write occurs in the same cycle.
- R7: `cal_busy` holds the calibration start bit. A `cal_done` pulse clears it in the next cycle, unless an accepted write occurs in the same cycle.
- R8: When an accepted write sets a start bit whose value after that cycle's completion would have been 0, the matching strobe (`conv_start` or `cal_start`) is 1 for one cycle. This cycle is the one in which the busy output first shows 1. Rewriting 1 into a start bit that is already busy gives no strobe.
- R9: If a completion pulse and an accepted write that sets the same start bit fall in the same cycle, the write wins: the busy output stays 1 and a new strobe is issued.
- R10: `coef_addr` carries the calibration-select field at all times. `coef_addr_valid` is 1 exactly when the calibration start bit is 0.
- R11: `cal_system` gives the calibration mode bit (0 = self, 1 = system), and `cal_sel` gives the calibration-select field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | 2 | Host register address |
| wr_data | input | 14 | Host write data |
| conv_done | input | 1 | One-cycle end-of-conversion pulse |
| cal_done | input | 1 | One-cycle end-of-calibration pulse |
| pm_mode | output | 2 | Power-management mode |
| rd_sel | output | 2 | Register chosen for later reads |
| twos_comp | output | 1 | Output coding: 1 = two's complement, bipolar |
| conv_busy | output | 1 | Stored conversion start bit |
| cal_busy | output | 1 | Stored calibration start bit |
| cal_system | output | 1 | Calibration mode: 1 = system |
| cal_sel | output | 2 | Calibration type selection |
| coef_addr | output | 2 | Calibration coefficient register address |
| coef_addr_valid | output | 1 | Coefficient address in force (no calibration running) |
| conv_start | output | 1 | One-cycle conversion start strobe |
| cal_start | output | 1 | One-cycle calibration start strobe |
| wr_err | output | 1 | Reserved-bit violation flag, one cycle |

## Verification
The bench aims at the collision cycle where a completion pulse meets a host write that sets the same start bit. A design that gave the pulse priority would drop the new request and stay silent. It also rewrites a start bit that is still busy; a design that strobed on every written 1 would launch a spurious second conversion. Writes with a reserved bit set and writes to other addresses are issued after known fields have been loaded. A design that checked the wrong bits, or decoded the address loosely, would then corrupt the power or read-select fields. The coefficient address valid flag is followed across a calibration start and end, which exposes a design that drops the dual meaning of the select field.

// File: rtl/adc_ctrl_pkg.sv
package adc_ctrl_pkg;

   localparam int CTRL_W    = 14;
   localparam int RESV_W    = 4;
   localparam int FIELD_W   = CTRL_W - RESV_W;

   localparam int POS_STCAL = 0;
   localparam int POS_CSEL  = 1;
   localparam int POS_CMODE = 3;
   localparam int POS_CONV  = 4;
   localparam int POS_RANGE = 5;
   localparam int POS_RSEL  = 6;
   localparam int POS_PM    = 8;

   typedef struct packed {
      logic [1:0] pm;
      logic [1:0] rsel;
      logic       range_bip;
      logic       conv;
      logic       cal_sys;
      logic [1:0] csel;
      logic       stcal;
   } ctrl_fields_t;

   localparam int NUM_STARTS = 2;
   localparam int IDX_CONV   = 0;
   localparam int IDX_CAL    = 1;

endpackage

// File: rtl/ctrl_write_decode.sv
module ctrl_write_decode
   import adc_ctrl_pkg::*;
#(
   parameter int          ADDR_W = 2,
   parameter int          DATA_W = CTRL_W,
   parameter int          RES_W  = RESV_W,
   parameter logic [ADDR_W-1:0] SEL_ADDR = '1
) (
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic              accept,
   output logic              reject,
   output ctrl_fields_t      fields
);
   localparam int FW = DATA_W - RES_W;

   generate
      if (FW != $bits(ctrl_fields_t)) begin : g_bad_width
         $error("ctrl_write_decode: field width does not match layout");
      end
   endgenerate

   logic selected;
   logic resv_set;

   assign selected = wr_en && (wr_addr == SEL_ADDR);
   assign resv_set = |wr_data[DATA_W-1:FW];
   assign accept   = selected && !resv_set;
   assign reject   = selected && resv_set;

   always_comb begin
      fields           = '0;
      fields.pm        = wr_data[POS_PM +: 2];
      fields.rsel      = wr_data[POS_RSEL +: 2];
      fields.range_bip = wr_data[POS_RANGE];
      fields.conv      = wr_data[POS_CONV];
      fields.cal_sys   = wr_data[POS_CMODE];
      fields.csel      = wr_data[POS_CSEL +: 2];
      fields.stcal     = wr_data[POS_STCAL];
   end

endmodule

// File: rtl/ctrl_field_store.sv
module ctrl_field_store
   import adc_ctrl_pkg::*;
(
   input  logic         clk,
   input  logic         rst_n,
   input  logic         accept,
   input  ctrl_fields_t new_fields,
   input  logic         conv_done,
   input  logic         cal_done,
   output ctrl_fields_t q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q <= '0;
      end else if (accept) begin
         q <= new_fields;
      end else begin
         if (conv_done) q.conv  <= 1'b0;
         if (cal_done)  q.stcal <= 1'b0;
      end
   end

   assert_conv_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (conv_done && !accept) |=> !q.conv);

   assert_cal_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (cal_done && !accept) |=> !q.stcal);

   assert_hold_fields_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !accept |=> ($stable(q.pm) && $stable(q.rsel) && $stable(q.csel)));

endmodule

// File: rtl/start_strobe.sv
module start_strobe #(
   parameter int N = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         accept,
   input  logic [N-1:0] req,
   input  logic [N-1:0] cur,
   input  logic [N-1:0] done,
   output logic [N-1:0] pulse
);
   generate
      if (N < 1) begin : g_bad_n
         $error("start_strobe: N must be at least 1");
      end
      for (genvar i = 0; i < N; i++) begin : g_bit
         logic was_idle;
         assign was_idle = !cur[i] || done[i];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pulse[i] <= 1'b0;
            else        pulse[i] <= accept && req[i] && was_idle;
         end
      end
   endgenerate

endmodule

// File: rtl/adc_ctrl_reg.sv
module adc_ctrl_reg
   import adc_ctrl_pkg::*;
#(
   parameter int ADDR_W = 2,
   parameter int DATA_W = CTRL_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              conv_done,
   input  logic              cal_done,
   output logic [1:0]        pm_mode,
   output logic [1:0]        rd_sel,
   output logic              twos_comp,
   output logic              conv_busy,
   output logic              cal_busy,
   output logic              cal_system,
   output logic [1:0]        cal_sel,
   output logic [1:0]        coef_addr,
   output logic              coef_addr_valid,
   output logic              conv_start,
   output logic              cal_start,
   output logic              wr_err
);
   generate
      if (DATA_W != CTRL_W) begin : g_bad_data
         $error("adc_ctrl_reg: DATA_W must equal the control word width");
      end
      if (ADDR_W < 1) begin : g_bad_addr
         $error("adc_ctrl_reg: ADDR_W must be positive");
      end
   endgenerate

   logic         accept;
   logic         reject;
   ctrl_fields_t wfields;
   ctrl_fields_t q;
   logic [NUM_STARTS-1:0] s_req, s_cur, s_done, s_pulse;

   ctrl_write_decode #(
      .ADDR_W  (ADDR_W),
      .DATA_W  (DATA_W),
      .RES_W   (DATA_W - FIELD_W),
      .SEL_ADDR({ADDR_W{1'b1}})
   ) i_dec (
      .wr_en  (wr_en),
      .wr_addr(wr_addr),
      .wr_data(wr_data),
      .accept (accept),
      .reject (reject),
      .fields (wfields)
   );

   ctrl_field_store i_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .accept    (accept),
      .new_fields(wfields),
      .conv_done (conv_done),
      .cal_done  (cal_done),
      .q         (q)
   );

   assign s_req[IDX_CONV]  = wfields.conv;
   assign s_req[IDX_CAL]   = wfields.stcal;
   assign s_cur[IDX_CONV]  = q.conv;
   assign s_cur[IDX_CAL]   = q.stcal;
   assign s_done[IDX_CONV] = conv_done;
   assign s_done[IDX_CAL]  = cal_done;

   start_strobe #(.N(NUM_STARTS)) i_strobe (
      .clk   (clk),
      .rst_n (rst_n),
      .accept(accept),
      .req   (s_req),
      .cur   (s_cur),
      .done  (s_done),
      .pulse (s_pulse)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) wr_err <= 1'b0;
      else        wr_err <= reject;
   end

   assign pm_mode         = q.pm;
   assign rd_sel          = q.rsel;
   assign twos_comp       = q.range_bip;
   assign conv_busy       = q.conv;
   assign cal_busy        = q.stcal;
   assign cal_system      = q.cal_sys;
   assign cal_sel         = q.csel;
   assign coef_addr       = q.csel;
   assign coef_addr_valid = !q.stcal;
   assign conv_start      = s_pulse[IDX_CONV];
   assign cal_start       = s_pulse[IDX_CAL];

   assert_conv_strobe_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
      conv_start |-> conv_busy);

   assert_cal_strobe_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
      cal_start |-> cal_busy);

   assert_reject_keeps_R4: assert property (@(posedge clk) disable iff (!rst_n)
      wr_err |-> (pm_mode == $past(pm_mode) && rd_sel == $past(rd_sel)
                  && twos_comp == $past(twos_comp)));

   assert_err_one_cycle_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_err && !reject) |=> !wr_err);

endmodule

// File: tb/test_adc_ctrl_reg.sv
module test_adc_ctrl_reg;
   localparam time CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_addr = '0;
   logic [13:0] wr_data = '0;
   logic        conv_done = 1'b0;
   logic        cal_done = 1'b0;
   logic [1:0]  pm_mode, rd_sel, cal_sel, coef_addr;
   logic        twos_comp, conv_busy, cal_busy, cal_system;
   logic        coef_addr_valid, conv_start, cal_start, wr_err;

   int n_chk = 0;
   int n_bad = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   adc_ctrl_reg i_adc_ctrl_reg (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .conv_done(conv_done), .cal_done(cal_done),
      .pm_mode(pm_mode), .rd_sel(rd_sel), .twos_comp(twos_comp),
      .conv_busy(conv_busy), .cal_busy(cal_busy), .cal_system(cal_system),
      .cal_sel(cal_sel), .coef_addr(coef_addr),
      .coef_addr_valid(coef_addr_valid), .conv_start(conv_start),
      .cal_start(cal_start), .wr_err(wr_err)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic logic [13:0] word(input logic [1:0] pm, input logic [1:0] rs,
      input logic rg, input logic cv, input logic cm, input logic [1:0] cs, input logic sc);
      return {4'b0000, pm, rs, rg, cv, cm, cs, sc};
   endfunction

   // one cycle: drive at negedge, sample at following negedge
   task automatic cyc(input logic we, input logic [1:0] a, input logic [13:0] d,
                      input logic cd, input logic kd);
      wr_en = we; wr_addr = a; wr_data = d; conv_done = cd; cal_done = kd;
      @(negedge clk);
      wr_en = 1'b0; conv_done = 1'b0; cal_done = 1'b0;
   endtask

   task automatic t_reset();
      check("R3 pm", pm_mode, 0);   check("R3 rsel", rd_sel, 0);
      check("R3 busy", {conv_busy, cal_busy}, 0);
      check("R3 strobes", {conv_start, cal_start, wr_err}, 0);
      check("R3 coef valid", coef_addr_valid, 1);
   endtask

   task automatic t_fields();
      cyc(1, 2'b11, word(2'b10, 2'b01, 1, 0, 1, 2'b11, 0), 0, 0);
      check("R1 pm", pm_mode, 2'b10);  check("R1 rsel", rd_sel, 2'b01);
      check("R5 twos", twos_comp, 1);
      check("R11 sys", cal_system, 1); check("R11 sel", cal_sel, 2'b11);
      check("R10 addr", coef_addr, 2'b11); check("R10 valid", coef_addr_valid, 1);
      cyc(1, 2'b11, word(2'b01, 2'b10, 0, 0, 0, 2'b01, 0), 0, 0);
      check("R5 unipolar", twos_comp, 0); check("R1 pm2", pm_mode, 2'b01);
   endtask

   task automatic t_other_addr();
      for (int a = 0; a < 3; a++) begin
         cyc(1, a[1:0], word(2'b11, 2'b11, 1, 1, 1, 2'b10, 1), 0, 0);
         check("R2 ignored", {pm_mode, rd_sel, twos_comp, conv_busy, cal_busy}, {2'b01, 2'b10, 3'b000});
         check("R2 no strobe", {conv_start, cal_start, wr_err}, 0);
      end
   endtask

   task automatic t_reserved();
      for (int b = 10; b < 14; b++) begin
         logic [13:0] d;
         d = word(2'b11, 2'b00, 1, 1, 0, 2'b00, 0);
         d[b] = 1'b1;
         cyc(1, 2'b11, d, 0, 0);
         check("R4 err", wr_err, 1);
         check("R4 kept", {pm_mode, rd_sel, twos_comp, conv_busy, conv_start}, {2'b01, 2'b10, 3'b000});
         @(negedge clk);
         check("R4 err drop", wr_err, 0);
      end
   endtask

   task automatic t_conv();
      cyc(1, 2'b11, word(2'b01, 2'b10, 0, 1, 0, 2'b01, 0), 0, 0);
      check("R8 conv strobe", conv_start, 1); check("R6 busy", conv_busy, 1);
      @(negedge clk);
      check("R8 one cycle", conv_start, 0); check("R6 held", conv_busy, 1);
      cyc(1, 2'b11, word(2'b01, 2'b10, 0, 1, 0, 2'b01, 0), 0, 0);
      check("R8 no restrobe", conv_start, 0);
      cyc(0, 2'b00, '0, 1, 0);
      check("R6 cleared", conv_busy, 0); check("R6 pm kept", pm_mode, 2'b01);
   endtask

   task automatic t_collision();
      cyc(1, 2'b11, word(0, 0, 0, 1, 0, 0, 0), 0, 0);
      @(negedge clk);
      cyc(1, 2'b11, word(0, 0, 0, 1, 0, 0, 0), 1, 0);
      check("R9 busy kept", conv_busy, 1); check("R9 new strobe", conv_start, 1);
      cyc(0, 2'b00, '0, 1, 0);
      check("R6 end", conv_busy, 0);
   endtask

   task automatic t_cal();
      cyc(1, 2'b11, word(0, 0, 0, 0, 1, 2'b10, 1), 0, 0);
      check("R8 cal strobe", cal_start, 1); check("R7 busy", cal_busy, 1);
      check("R10 invalid", coef_addr_valid, 0); check("R11 type", cal_sel, 2'b10);
      @(negedge clk);
      check("R8 cal one", cal_start, 0);
      cyc(0, 2'b00, '0, 0, 1);
      check("R7 cleared", cal_busy, 0); check("R10 valid again", coef_addr_valid, 1);
      check("R10 addr", coef_addr, 2'b10);
      cyc(1, 2'b11, word(0, 0, 0, 0, 0, 2'b01, 1), 0, 1);
      check("R9 cal write wins", {cal_busy, cal_start}, 2'b11);
   endtask

   initial begin
      fork
         begin
            @(negedge clk); @(negedge clk);
            rst_n = 1'b1;
            @(negedge clk);
            t_reset();
            t_fields();
            t_other_addr();
            t_reserved();
            t_conv();
            t_collision();
            t_cal();
         end
         begin
            repeat (5000) @(posedge clk);
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      disable fork;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule